// File: doc/BRIEF.md
# Presentation timestamp sync comparator

The block holds a local copy of the system time base and judges, for the audio stream and the video stream separately, whether each presentation unit reaches the output on time. The host corrects every presentation timestamp for its own system delays and writes it into a per-stream slot. When the decoder signals that a unit is being presented, the block subtracts the slot's timestamp from the local time. A result that is positive and larger than a programmable tolerance means the unit arrived late, and the decoder is told to skip a frame. A result that is negative and larger than the tolerance means it arrived early, and the decoder is told to repeat one. Because this check runs again on each unit, the streams move toward lock step by step.

The local time is a 33-bit count of 90 kHz periods. It is derived from a 27 MHz enable divided by a parameter (300 by default) and wraps modulo 2^33. The host can load it at any time. The error is formed modulo 2^33 and widened to 34 signed bits, so a time base that has just wrapped still gives the correct sign. Each slot carries a pending flag. A write sets the flag and a comparison consumes it, so a timestamp is never used twice. The last error and the last decision of each stream stay on output ports.

Top module: `pts_sync_cmp`

## Requirements
- R1: After synchronous reset, the time base reads 0, both pending flags are 0, both skip and repeat outputs are 0, both error outputs are 0, and both decision outputs read 2'b00.
- R2: The time base grows by exactly one after every DIV cycles in which `tick_27m` is high, counting the cycles since the last load. It holds its value at all other times and wraps from 2^33-1 to 0.
- R3: A host write with address 0 loads `host_wdata` into the time base and restarts the divider. Address 1 stores the audio timestamp and address 2 stores the video timestamp; each of these writes sets that stream's pending flag. Address 3 stores the low THR_W bits as the tolerance.
- R4: On a present strobe with the pending flag set, the error output in the next cycle equals (time base - timestamp) mod 2^33, read as a signed 33-bit value and sign-extended to 34 bits.
- R5: If that error is greater than the tolerance, the stream's skip output is high for exactly one cycle and its decision reads 2'b01.
- R6: If that error is less than minus the tolerance, the stream's repeat output is high for exactly one cycle and its decision reads 2'b10.
- R7: If the error's magnitude is no greater than the tolerance, neither pulse appears and the decision reads 2'b00.
- R8: A comparison clears the stream's pending flag. A present strobe while the flag is clear produces no pulse and leaves that stream's error and decision unchanged.
- R9: The audio and video slots are judged independently. A strobe on one stream never changes the other stream's pulses, error, decision or pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_27m | input | 1 | 27 MHz rate enable that feeds the divider |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select (0 time base, 1 audio, 2 video, 3 tolerance) |
| host_wdata | input | 33 | Host write data |
| a_present | input | 1 | Audio unit presented this cycle |
| v_present | input | 1 | Video unit presented this cycle |
| stc_now | output | 33 | Current local time base |
| a_pending | output | 1 | Audio timestamp waiting for comparison |
| v_pending | output | 1 | Video timestamp waiting for comparison |
| a_skip | output | 1 | One-cycle audio skip-frame command |
| a_repeat | output | 1 | One-cycle audio repeat-frame command |
| v_skip | output | 1 | One-cycle video skip-frame command |
| v_repeat | output | 1 | One-cycle video repeat-frame command |
| a_err | output | 34 | Last audio error, signed |
| v_err | output | 34 | Last video error, signed |
| a_decision | output | 2 | Last audio decision (00 none, 01 skip, 10 repeat) |
| v_decision | output | 2 | Last video decision (00 none, 01 skip, 10 repeat) |

## Verification
A wrong divider count or a lost load appears on `stc_now` within one divider period. The stimulus holds the enable low whenever it tests a comparison, so each expected error is exact. A slot that keeps its pending flag after a comparison, or that latches the wrong timestamp, shows up one cycle after the next strobe: the pulse, error or decision will be wrong. Tests placed exactly at plus and minus the tolerance, and just beyond it, catch an off-by-one in the band edges. Timestamps on either side of the 2^33 wrap catch a subtraction that is not modular.

// File: rtl/pts_sync_pkg.sv
package pts_sync_pkg;

    localparam int STC_W = 33;
    localparam int ERR_W = STC_W + 1;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_SKIP   = 2'b01,
        ACT_REPEAT = 2'b10
    } sync_act_e;

    typedef enum logic [1:0] {
        REG_STC    = 2'd0,
        REG_TS_AUD = 2'd1,
        REG_TS_VID = 2'd2,
        REG_THRESH = 2'd3
    } host_reg_e;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        sync_act_e        act;
    } cmp_result_t;

    // Modular difference, read as signed 33-bit and widened by one bit.
    function automatic logic [ERR_W-1:0] wrap_diff(
        input logic [STC_W-1:0] now_t,
        input logic [STC_W-1:0] due_t
    );
        logic [STC_W-1:0] d;
        d = now_t - due_t;
        return {d[STC_W-1], d};
    endfunction

    function automatic sync_act_e classify(
        input logic signed [ERR_W-1:0] e,
        input logic        [ERR_W-1:0] tol
    );
        if (e > $signed(tol))
            return ACT_SKIP;
        else if (e < -$signed(tol))
            return ACT_REPEAT;
        else
            return ACT_NONE;
    endfunction

endpackage

// File: rtl/stc_counter.sv
module stc_counter
    import pts_sync_pkg::*;
#(
    parameter int DIV = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [STC_W-1:0] load_val,
    output logic [STC_W-1:0] stc
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            stc   <= '0;
        end else if (load) begin
            pre_q <= '0;
            stc   <= load_val;
        end else if (tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                stc   <= stc + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    AST_STC_STEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> (stc == $past(stc) || stc == $past(stc) + 1'b1)); // R2

endmodule

// File: rtl/ts_slot.sv
module ts_slot
    import pts_sync_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [STC_W-1:0] wr_ts,
    input  logic             present,
    input  logic [STC_W-1:0] stc,
    input  logic [THR_W-1:0] thr,
    output logic             pending,
    output logic             skip,
    output logic             repeat_f,
    output logic [ERR_W-1:0] err,
    output sync_act_e        act
);

    localparam int PAD = ERR_W - THR_W;

    logic [STC_W-1:0] ts_q;
    logic [ERR_W-1:0] tol_w;
    cmp_result_t      res_n;
    logic             fire;

    assign tol_w     = {{PAD{1'b0}}, thr};
    assign fire      = present && pending;
    assign res_n.err = wrap_diff(stc, ts_q);
    assign res_n.act = classify(res_n.err, tol_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q     <= '0;
            pending  <= 1'b0;
            skip     <= 1'b0;
            repeat_f <= 1'b0;
            err      <= '0;
            act      <= ACT_NONE;
        end else begin
            skip     <= 1'b0;
            repeat_f <= 1'b0;
            if (fire) begin
                err      <= res_n.err;
                act      <= res_n.act;
                skip     <= (res_n.act == ACT_SKIP);
                repeat_f <= (res_n.act == ACT_REPEAT);
            end
            if (wr) begin
                ts_q    <= wr_ts;
                pending <= 1'b1;
            end else if (present) begin
                pending <= 1'b0;
            end
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(skip && repeat_f)); // R5

    AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        skip |-> $past(present && pending)); // R8

    AST_SKIP_OUT_OF_BAND: assert property (@(posedge clk) disable iff (rst)
        skip |-> ($signed(err) > $signed({{PAD{1'b0}}, $past(thr)}))); // R5

    AST_REPEAT_OUT_OF_BAND: assert property (@(posedge clk) disable iff (rst)
        repeat_f |-> ($signed(err) < -$signed({{PAD{1'b0}}, $past(thr)}))); // R6

    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (present && pending && !wr) |=> !pending); // R8

endmodule

// File: rtl/pts_sync_cmp.sv
module pts_sync_cmp
    import pts_sync_pkg::*;
#(
    parameter int DIV     = 300,
    parameter int THR_W   = 16,
    parameter int DEF_THR = 90
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_27m,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [32:0] host_wdata,
    input  logic        a_present,
    input  logic        v_present,
    output logic [32:0] stc_now,
    output logic        a_pending,
    output logic        v_pending,
    output logic        a_skip,
    output logic        a_repeat,
    output logic        v_skip,
    output logic        v_repeat,
    output logic [33:0] a_err,
    output logic [33:0] v_err,
    output logic [1:0]  a_decision,
    output logic [1:0]  v_decision
);

    localparam int NSTR = 2;

    host_reg_e        sel;
    logic [THR_W-1:0] thr_q;
    logic [STC_W-1:0] stc_w;
    logic [NSTR-1:0]  pres_w;
    logic [NSTR-1:0]  pend_w;
    logic [NSTR-1:0]  skip_w;
    logic [NSTR-1:0]  rep_w;
    logic [ERR_W-1:0] err_w [NSTR];
    sync_act_e        act_w [NSTR];

    assign sel    = host_reg_e'(host_addr);
    assign pres_w = {v_present, a_present};

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= THR_W'(DEF_THR);
        else if (host_we && sel == REG_THRESH)
            thr_q <= host_wdata[THR_W-1:0];
    end

    stc_counter #(.DIV(DIV)) u_stc (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_27m),
        .load     (host_we && sel == REG_STC),
        .load_val (host_wdata),
        .stc      (stc_w)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_slot
        localparam host_reg_e MY_REG = (s == 0) ? REG_TS_AUD : REG_TS_VID;
        ts_slot #(.THR_W(THR_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr       (host_we && sel == MY_REG),
            .wr_ts    (host_wdata),
            .present  (pres_w[s]),
            .stc      (stc_w),
            .thr      (thr_q),
            .pending  (pend_w[s]),
            .skip     (skip_w[s]),
            .repeat_f (rep_w[s]),
            .err      (err_w[s]),
            .act      (act_w[s])
        );
    end

    assign stc_now    = stc_w;
    assign a_pending  = pend_w[0];
    assign v_pending  = pend_w[1];
    assign a_skip     = skip_w[0];
    assign v_skip     = skip_w[1];
    assign a_repeat   = rep_w[0];
    assign v_repeat   = rep_w[1];
    assign a_err      = err_w[0];
    assign v_err      = err_w[1];
    assign a_decision = act_w[0];
    assign v_decision = act_w[1];

    AST_STREAMS_APART: assert property (@(posedge clk) disable iff (rst)
        (!$past(v_present) && !$past(host_we)) |-> (v_decision == $past(v_decision))); // R9

endmodule

// File: tb/pts_sync_cmp_test.sv
module pts_sync_cmp_test;

    localparam int DIV = 4;
    localparam logic [32:0] TOP = 33'h1_FFFF_FFFF;

    typedef struct {
        logic        skip;
        logic        rep;
        logic [33:0] err;
        logic [1:0]  act;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_27m = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [32:0] host_wdata = '0;
    logic        a_present = 1'b0;
    logic        v_present = 1'b0;
    logic [32:0] stc_now;
    logic        a_pending, v_pending, a_skip, a_repeat, v_skip, v_repeat;
    logic [33:0] a_err, v_err;
    logic [1:0]  a_decision, v_decision;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [32:0] m_stc;
    logic [32:0] m_ts [2];
    bit          m_pend [2];
    logic [15:0] m_thr;
    exp_t        m_last [2];
    exp_t        q_a [$];
    exp_t        q_v [$];
    logic [1:0]  seen = 2'b00;

    always #2 clk = ~clk;

    pts_sync_cmp #(.DIV(DIV), .THR_W(16), .DEF_THR(10)) uut (
        .clk(clk), .rst(rst), .tick_27m(tick_27m),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .a_present(a_present), .v_present(v_present),
        .stc_now(stc_now), .a_pending(a_pending), .v_pending(v_pending),
        .a_skip(a_skip), .a_repeat(a_repeat), .v_skip(v_skip), .v_repeat(v_repeat),
        .a_err(a_err), .v_err(v_err), .a_decision(a_decision), .v_decision(v_decision)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act_v,
                         input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    function automatic exp_t predict(input logic [32:0] now_t, input logic [32:0] ts,
                                     input logic [15:0] tol);
        exp_t r;
        logic [32:0] d;
        logic signed [33:0] e;
        logic signed [33:0] t;
        d = now_t - ts;
        e = {d[32], d};
        t = {18'd0, tol};
        r.err  = e;
        r.skip = (e > t);
        r.rep  = (e < -t);
        r.act  = r.skip ? 2'b01 : (r.rep ? 2'b10 : 2'b00);
        return r;
    endfunction

    task automatic host_write(input logic [1:0] addr, input logic [32:0] data);
        @(negedge clk);
        host_we = 1'b1; host_addr = addr; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
        case (addr)
            2'd0: m_stc = data;
            2'd1: begin m_ts[0] = data; m_pend[0] = 1'b1; end
            2'd2: begin m_ts[1] = data; m_pend[1] = 1'b1; end
            default: m_thr = data[15:0];
        endcase
    endtask

    // Driver: predicts each stream's result and queues it for the monitor.
    task automatic fire(input bit aud, input bit vid);
        exp_t e;
        for (int s = 0; s < 2; s++) begin
            if ((s == 0 && aud) || (s == 1 && vid)) begin
                if (m_pend[s]) begin
                    e = predict(m_stc, m_ts[s], m_thr);
                    m_last[s] = e;
                    m_pend[s] = 1'b0;
                end else begin
                    e = m_last[s];
                    e.skip = 1'b0;
                    e.rep  = 1'b0;
                end
                if (s == 0) q_a.push_back(e); else q_v.push_back(e);
            end
        end
        @(negedge clk);
        a_present = aud; v_present = vid;
        @(negedge clk);
        a_present = 1'b0; v_present = 1'b0;
    endtask

    always @(posedge clk) seen <= {v_present, a_present};

    // Monitor: compares each stream's outputs against the queued prediction.
    always @(negedge clk) begin
        if (!rst) begin
            if (seen[0]) begin
                if (q_a.size() == 0) check(1'b0, "R4 audio unexpected result", 0, 0);
                else begin
                    exp_t e;
                    e = q_a.pop_front();
                    check(a_skip == e.skip, "R5 audio skip", a_skip, e.skip);
                    check(a_repeat == e.rep, "R6 audio repeat", a_repeat, e.rep);
                    check(a_err == e.err, "R4 audio error", a_err, e.err);
                    check(a_decision == e.act, "R7 audio decision", a_decision, e.act);
                end
            end else if (a_skip || a_repeat) begin
                check(1'b0, "R8 audio pulse without strobe", {a_skip, a_repeat}, 0);
            end
            if (seen[1]) begin
                if (q_v.size() == 0) check(1'b0, "R4 video unexpected result", 0, 0);
                else begin
                    exp_t e;
                    e = q_v.pop_front();
                    check(v_skip == e.skip, "R5 video skip", v_skip, e.skip);
                    check(v_repeat == e.rep, "R6 video repeat", v_repeat, e.rep);
                    check(v_err == e.err, "R4 video error", v_err, e.err);
                    check(v_decision == e.act, "R7 video decision", v_decision, e.act);
                end
            end else if (v_skip || v_repeat) begin
                check(1'b0, "R9 video pulse without strobe", {v_skip, v_repeat}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_stc = '0; m_thr = 16'd10;
        for (int s = 0; s < 2; s++) begin
            m_ts[s] = '0; m_pend[s] = 1'b0;
            m_last[s].skip = 1'b0; m_last[s].rep = 1'b0;
            m_last[s].err = '0; m_last[s].act = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(stc_now == 0, "R1 time base", stc_now, 0);
        check(!a_pending && !v_pending, "R1 pending", {a_pending, v_pending}, 0);
        check({a_skip, a_repeat, v_skip, v_repeat} == 0, "R1 pulses",
              {a_skip, a_repeat, v_skip, v_repeat}, 0);
        check(a_err == 0 && v_err == 0, "R1 errors", a_err, 0);
        check(a_decision == 0 && v_decision == 0, "R1 decisions", {a_decision, v_decision}, 0);

        // R2 divider: DIV-1 ticks hold, the DIV-th advances
        tick_27m = 1'b1;
        repeat (DIV - 1) @(negedge clk);
        check(stc_now == 0, "R2 hold before divide", stc_now, 0);
        @(negedge clk);
        tick_27m = 1'b0;
        check(stc_now == 1, "R2 advance after divide", stc_now, 1);
        repeat (3) @(negedge clk);
        check(stc_now == 1, "R2 hold without tick", stc_now, 1);

        // R2 wrap, R3 load
        host_write(2'd0, TOP);
        check(stc_now == TOP, "R3 load time base", stc_now, TOP);
        tick_27m = 1'b1;
        repeat (DIV) @(negedge clk);
        tick_27m = 1'b0;
        check(stc_now == 0, "R2 wrap to zero", stc_now, 0);

        host_write(2'd0, 33'd1000);
        check(stc_now == 33'd1000, "R3 load 1000", stc_now, 33'd1000);
        host_write(2'd1, 33'd990);
        check(a_pending && !v_pending, "R3 audio pending only", {a_pending, v_pending}, 2'b10);

        fire(1'b1, 1'b0);                              // R7 error +10 at band edge
        check(!a_pending, "R8 pending cleared", a_pending, 0);
        host_write(2'd1, 33'd989); fire(1'b1, 1'b0);   // R5 error +11
        host_write(2'd1, 33'd1010); fire(1'b1, 1'b0);  // R7 error -10
        host_write(2'd1, 33'd1011); fire(1'b1, 1'b0);  // R6 error -11
        fire(1'b1, 1'b0);                              // R8 stale strobe
        check(a_decision == 2'b10, "R8 stale keeps decision", a_decision, 2'b10);

        // R4 across the wrap
        host_write(2'd0, 33'd5);
        host_write(2'd1, TOP - 33'd2); fire(1'b1, 1'b0);   // +8, inside band
        host_write(2'd3, 33'd3);
        host_write(2'd1, TOP - 33'd2); fire(1'b1, 1'b0);   // +8, now skip
        host_write(2'd0, TOP - 33'd1);
        host_write(2'd1, 33'd3); fire(1'b1, 1'b0);         // -5, repeat
        host_write(2'd0, 33'd0);
        host_write(2'd1, 33'h1_0000_0000); fire(1'b1, 1'b0); // most negative half

        // R9 independence
        host_write(2'd3, 33'd10);
        host_write(2'd0, 33'd1000);
        host_write(2'd1, 33'd900);
        host_write(2'd2, 33'd1100);
        fire(1'b1, 1'b1);
        host_write(2'd2, 33'd995);
        fire(1'b0, 1'b1);
        check(a_decision == 2'b01, "R9 audio untouched by video", a_decision, 2'b01);
        check(a_err == 34'd100, "R9 audio error kept", a_err, 34'd100);
        host_write(2'd1, 33'd500);
        fire(1'b0, 1'b1);                              // video stale, audio pending
        check(a_pending, "R9 audio pending kept", a_pending, 1);

        repeat (3) @(negedge clk);
        check(q_a.size() == 0 && q_v.size() == 0, "R4 all results seen",
              q_a.size() + q_v.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule